// File: doc/BRIEF.md
# Signed Number Format Converter

This block re-encodes a signed integer from one of three binary signed encodings into another. The supported encodings are sign-and-magnitude, ones' complement and two's complement. Each transfer carries a data word, a code that names its encoding and a code that names the encoding wanted at the output. The result appears one clock later with a valid strobe.

Two corner cases are reported on flags. Sign-and-magnitude and ones' complement each have a negative-zero pattern. The block folds that pattern to plain zero and raises a flag. The most negative two's complement value has no counterpart in the other two encodings. When it is sent to either of them, the block raises an unrepresentable flag and drives zero on the data output. The word width is a parameter, with a default of 7 bits.

Top module: `sfmt_conv`

## Requirements
- R1: The format codes are 0 for sign-and-magnitude, 1 for ones' complement and 2 for two's complement. Code 3 is handled as two's complement, both as a source and as a target.
- R2: An input word whose most significant bit is 0 is output unchanged for every source and target pair.
- R3: A negative, non-zero input is output as the same value in the target encoding:
  - In sign-and-magnitude, the most significant bit is 1 and the lower bits are the magnitude.
  - In ones' complement, every bit of the positive pattern is inverted.
  - In two's complement, the pattern is the ones' complement plus 1.
- R4: A negative-zero input gives an all-zero output word and sets out_negzero, for any target. The negative-zero patterns are 1 followed by zeros in sign-and-magnitude, and all ones in ones' complement.
- R5: The most negative two's complement value is 1 followed by zeros. Sent to a sign-and-magnitude or ones' complement target, it gives an all-zero output word and sets out_unrep. Sent to a two's complement target, it passes unchanged and out_unrep stays 0.
- R6: out_valid is 1 exactly in the cycle after a cycle with in_valid at 1.
- R7: While in_valid is 0, out_data, out_unrep and out_negzero keep their values.
- R8: A synchronous reset clears out_valid, out_data, out_unrep and out_negzero to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is valid this cycle |
| in_data | input | WIDTH | Input word |
| src_fmt | input | 2 | Encoding of in_data |
| dst_fmt | input | 2 | Encoding wanted on out_data |
| out_valid | output | 1 | Result valid |
| out_data | output | WIDTH | Converted word |
| out_unrep | output | 1 | Value cannot be held by the target encoding |
| out_negzero | output | 1 | Input was a negative zero |

## Verification
Every result is due in the cycle after the strobe that carries the input. This applies to the converted word, both flags and out_valid. The bench drives inputs on the falling edge and holds in_valid for one cycle. It compares the results at the following falling edge, one rising edge later. It then checks that out_valid drops one edge after that, and that the held outputs stay put while new data is offered without a strobe.

// File: rtl/sfmt_conv.sv
module sfmt_conv #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [WIDTH-1:0] in_data,
  input  logic [1:0]       src_fmt,
  input  logic [1:0]       dst_fmt,
  output logic             out_valid,
  output logic [WIDTH-1:0] out_data,
  output logic             out_unrep,
  output logic             out_negzero
);

  localparam logic [1:0] FMT_SM = 2'd0;
  localparam logic [1:0] FMT_OC = 2'd1;

  logic             neg_bit;
  logic [WIDTH-1:0] mag;
  logic             is_negzero;
  logic             neg_val;
  logic             cant_hold;
  logic [WIDTH-1:0] enc;

  assign neg_bit = in_data[WIDTH-1];

  always_comb begin
    case (src_fmt)
      FMT_SM:  mag = {1'b0, in_data[WIDTH-2:0]};
      FMT_OC:  mag = neg_bit ? {1'b0, ~in_data[WIDTH-2:0]} : in_data;
      default: mag = neg_bit ? (~in_data + 1'b1) : in_data;
    endcase
  end

  assign is_negzero = neg_bit && (mag == '0);
  assign neg_val    = neg_bit && (mag != '0);
  assign cant_hold  = mag[WIDTH-1] && (dst_fmt == FMT_SM || dst_fmt == FMT_OC);

  always_comb begin
    if (!neg_val || cant_hold)
      enc = neg_val ? '0 : mag;
    else begin
      case (dst_fmt)
        FMT_SM:  enc = {1'b1, mag[WIDTH-2:0]};
        FMT_OC:  enc = ~mag;
        default: enc = ~mag + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_unrep   <= 1'b0;
      out_negzero <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data    <= enc;
        out_unrep   <= cant_hold;
        out_negzero <= is_negzero;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R6
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R6
  AST_POS_PASSES: assert property (@(posedge clk) disable iff (rst) (in_valid && !in_data[WIDTH-1]) |=> (out_data == $past(in_data) && !out_unrep && !out_negzero)); // R2
  AST_NEGZERO_CLEAN: assert property (@(posedge clk) disable iff (rst) out_negzero |-> (out_data == '0 && !out_unrep)); // R4
  AST_UNREP_CLEAN: assert property (@(posedge clk) disable iff (rst) out_unrep |-> (out_data == '0)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ($stable(out_data) && $stable(out_unrep) && $stable(out_negzero))); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!out_valid && out_data == '0 && !out_unrep && !out_negzero)); // R8

endmodule

// File: tb/test_sfmt_conv.sv
module test_sfmt_conv;
  localparam int W = 7;
  localparam int NV = 18;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic [1:0] src_fmt = '0, dst_fmt = '0;
  logic out_valid, out_unrep, out_negzero;
  logic [W-1:0] out_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sfmt_conv #(.WIDTH(W)) i_sfmt_conv (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .src_fmt(src_fmt), .dst_fmt(dst_fmt), .out_valid(out_valid),
    .out_data(out_data), .out_unrep(out_unrep), .out_negzero(out_negzero)
  );

  // Fields: src, dst, input, expected word, expected unrep, expected negzero
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 2'd2, 7'b1000101, 7'b1111011, 1'b0, 1'b0}, // R3 -5
    {2'd0, 2'd1, 7'b1000101, 7'b1111010, 1'b0, 1'b0}, // R3
    {2'd1, 2'd0, 7'b1010100, 7'b1101011, 1'b0, 1'b0}, // R3 -43
    {2'd1, 2'd2, 7'b1010100, 7'b1010101, 1'b0, 1'b0}, // R3
    {2'd2, 2'd0, 7'b1010101, 7'b1101011, 1'b0, 1'b0}, // R3
    {2'd2, 2'd1, 7'b1111111, 7'b1111110, 1'b0, 1'b0}, // R3 -1
    {2'd2, 2'd0, 7'b1000001, 7'b1111111, 1'b0, 1'b0}, // R3 -63
    {2'd0, 2'd1, 7'b1111111, 7'b1000000, 1'b0, 1'b0}, // R3
    {2'd0, 2'd0, 7'b0101011, 7'b0101011, 1'b0, 1'b0}, // R2
    {2'd2, 2'd1, 7'b0011010, 7'b0011010, 1'b0, 1'b0}, // R2
    {2'd0, 2'd2, 7'b1000000, 7'b0000000, 1'b0, 1'b1}, // R4
    {2'd1, 2'd2, 7'b1111111, 7'b0000000, 1'b0, 1'b1}, // R4
    {2'd1, 2'd0, 7'b1111111, 7'b0000000, 1'b0, 1'b1}, // R4
    {2'd2, 2'd0, 7'b1000000, 7'b0000000, 1'b1, 1'b0}, // R5
    {2'd2, 2'd1, 7'b1000000, 7'b0000000, 1'b1, 1'b0}, // R5
    {2'd2, 2'd2, 7'b1000000, 7'b1000000, 1'b0, 1'b0}, // R5
    {2'd3, 2'd0, 7'b1111011, 7'b1000101, 1'b0, 1'b0}, // R1 code 3 source
    {2'd1, 2'd3, 7'b1010100, 7'b1010101, 1'b0, 1'b0}  // R1 code 3 target
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] s, input logic [1:0] d, input logic [W-1:0] x);
    @(negedge clk);
    src_fmt = s; dst_fmt = d; in_data = x; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset outputs", {out_valid, out_unrep, out_negzero, 25'd0, out_data}, 32'd0);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][19:18], VEC[i][17:16], VEC[i][15:9]);
      check($sformatf("R1/R6 vector %0d valid", i), {31'd0, out_valid}, 32'd1);
      check($sformatf("vector %0d word", i), {25'd0, out_data}, {25'd0, VEC[i][8:2]});
      check($sformatf("vector %0d unrep", i), {31'd0, out_unrep}, {31'd0, VEC[i][1]});
      check($sformatf("vector %0d negzero", i), {31'd0, out_negzero}, {31'd0, VEC[i][0]});
    end

    // R6: strobe low for one cycle gives out_valid low
    @(negedge clk);
    check("R6 valid drops", {31'd0, out_valid}, 32'd0);

    // R7: new data without strobe leaves outputs unchanged
    apply(2'd2, 2'd0, 7'b1000000);
    check("R7 setup unrep", {31'd0, out_unrep}, 32'd1);
    @(negedge clk);
    src_fmt = 2'd0; dst_fmt = 2'd2; in_data = 7'b1000101;
    @(negedge clk);
    @(negedge clk);
    check("R7 hold word", {25'd0, out_data}, 32'd0);
    check("R7 hold unrep", {31'd0, out_unrep}, 32'd1);
    check("R7 hold valid", {31'd0, out_valid}, 32'd0);

    // R8: mid-run reset clears everything
    apply(2'd0, 2'd2, 7'b1000101);
    check("R8 pre-reset word", {25'd0, out_data}, {25'd0, 7'b1111011});
    rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 reset clears", {out_valid, out_unrep, out_negzero, 25'd0, out_data}, 32'd0);
    rst = 1'b0;

    // R4 after reset: negative zero into sign-and-magnitude target
    apply(2'd0, 2'd0, 7'b1000000);
    check("R4 sm to sm negzero", {out_negzero, 24'd0, out_data}, {1'b1, 31'd0});

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule